// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block is the output gating stage of a multi-output clock generator. It receives the internally generated CPU, PCI, AGP, SDRAM, reference and USB clocks and passes each one to its output through a clock gate. Three active-low board controls decide which gates are open: CPU stop, PCI stop and power-down. The controls act only while the mode input is low. When mode is high, the controls are ignored and every clock runs, subject only to its configuration enable.

Every control is asynchronous to the clocks. In each clock domain it affects, the control passes through its own multi-flop synchronizer, on that domain's rising edge. The synchronized request is then captured on the falling edge and ANDed with the clock. A gate therefore opens or closes only while its clock is low, so no shortened high pulse can appear. One PCI output is free running: it ignores PCI stop. The AGP, SDRAM, reference and USB outputs ignore both stop controls and halt only on power-down. Every output also has its own configuration enable bit.

Top module: `clk_stop_gate`

## Requirements
- R1: After the asynchronous reset is released, with all enables at 1 and all controls high, every output toggles with its source clock. Reset itself leaves every synchronizer and gate in the running state.
- R2: While mode_i is 1, cpu_stop_ni, pci_stop_ni and pwr_dn_ni have no effect. Each output then runs exactly when its enable bit is 1.
- R3: While mode_i is 0 and cpu_stop_ni is 0 (active low), every bit of cpu_clk_o is held at 0. All other outputs are unaffected by this control.
- R4: A control change applied during the high phase that follows rising edge E0 of a domain's clock is first seen in the high phase that starts at E3. The high phases at E1 and E2 still reflect the previous state. This holds both for stopping and for restarting, with the default of 2 synchronizer stages, and it holds for the CPU and the PCI domains.
- R5: While mode_i is 0 and pci_stop_ni is 0, every bit of pci_clk_o is held at 0, and pci_free_clk_o keeps toggling.
- R6: agp_clk_o, sdram_clk_o, ref_clk_o and usb_clk_o keep toggling while either stop control is 0, as long as pwr_dn_ni is 1.
- R7: While mode_i is 0 and pwr_dn_ni is 0, every output is held at 0, including the free-running PCI, AGP, reference and USB outputs.
- R8: Bit i of each enable vector gates output bit i of the same group (1 = active, 0 = held at 0). The enable bits act independently of one another and combine with the controls.
- R9: An output is never high while its source clock is low. The gate state changes only on the clock's falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk_i | input | 1 | CPU source clock |
| pci_clk_i | input | 1 | PCI source clock, shared by the gated and the free-running PCI outputs |
| agp_clk_i | input | 1 | AGP source clock |
| sdram_clk_i | input | 1 | SDRAM source clock |
| ref_clk_i | input | 1 | Reference source clock |
| usb_clk_i | input | 1 | USB source clock |
| rst_ni | input | 1 | Asynchronous active-low reset; sets every lane to running |
| mode_i | input | 1 | 0: the controls are honoured; 1: the controls are ignored |
| cpu_stop_ni | input | 1 | Active-low CPU stop, asynchronous |
| pci_stop_ni | input | 1 | Active-low PCI stop, asynchronous |
| pwr_dn_ni | input | 1 | Active-low power-down, asynchronous |
| cpu_en_i | input | N_CPU | Per-output enables for the CPU outputs |
| pci_en_i | input | N_PCI | Per-output enables for the gated PCI outputs |
| pci_free_en_i | input | 1 | Enable for the free-running PCI output |
| agp_en_i | input | N_AGP | Per-output enables for the AGP outputs |
| sdram_en_i | input | N_SDRAM | Per-output enables for the SDRAM outputs |
| ref_en_i | input | 1 | Enable for the reference output |
| usb_en_i | input | 1 | Enable for the USB output |
| cpu_clk_o | output | N_CPU | Gated CPU clocks |
| pci_clk_o | output | N_PCI | Gated PCI clocks |
| pci_free_clk_o | output | 1 | Free-running PCI clock |
| agp_clk_o | output | N_AGP | Gated AGP clocks |
| sdram_clk_o | output | N_SDRAM | Gated SDRAM clocks |
| ref_clk_o | output | 1 | Gated reference clock |
| usb_clk_o | output | 1 | Gated USB clock |

## Verification
The bench uses the default parameters: 4 CPU outputs, 4 gated PCI outputs, 2 AGP outputs, 12 SDRAM outputs and 2 synchronizer stages. It runs six unrelated source clock periods, so every domain's synchronizer sees the controls arrive at a different phase. With 2 stages, the E1/E2/E3 latency window of R4 is a fixed, edge-exact expectation for both the CPU and the PCI domains. The 25 output bits are wide enough to exercise irregular per-bit enable patterns together with the stop and power-down controls.

// File: rtl/ckg_pkg.sv
package ckg_pkg;
  // A lane runs when the controls are bypassed or all its controls are released.
  function automatic logic run_req(input logic mode, input logic stop_n, input logic pwr_n);
    return mode | (stop_n & pwr_n);
  endfunction
endpackage

// File: rtl/ckg_sync.sv
module ckg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  // Reset value is "running".
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '1;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ckg_gate_lane.sv
module ckg_gate_lane #(
  parameter int N      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] clk_o
);
  logic [N-1:0] req;
  logic [N-1:0] req_s;
  logic [N-1:0] gate_q;

  assign req = en_i & {N{run_i}};

  ckg_sync #(.W(N), .STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req),
    .q_o   (req_s)
  );

  // Capture on the falling edge: the gate only moves while the clock is low.
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= '1;
    else         gate_q <= req_s;
  end

  for (genvar i = 0; i < N; i++) begin : g_gate
    assign clk_o[i] = clk_i & gate_q[i];
  end
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate
  import ckg_pkg::*;
#(
  parameter int N_CPU       = 4,
  parameter int N_PCI       = 4,
  parameter int N_AGP       = 2,
  parameter int N_SDRAM     = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic               cpu_clk_i,
  input  logic               pci_clk_i,
  input  logic               agp_clk_i,
  input  logic               sdram_clk_i,
  input  logic               ref_clk_i,
  input  logic               usb_clk_i,
  input  logic               rst_ni,
  input  logic               mode_i,
  input  logic               cpu_stop_ni,
  input  logic               pci_stop_ni,
  input  logic               pwr_dn_ni,
  input  logic [N_CPU-1:0]   cpu_en_i,
  input  logic [N_PCI-1:0]   pci_en_i,
  input  logic               pci_free_en_i,
  input  logic [N_AGP-1:0]   agp_en_i,
  input  logic [N_SDRAM-1:0] sdram_en_i,
  input  logic               ref_en_i,
  input  logic               usb_en_i,
  output logic [N_CPU-1:0]   cpu_clk_o,
  output logic [N_PCI-1:0]   pci_clk_o,
  output logic               pci_free_clk_o,
  output logic [N_AGP-1:0]   agp_clk_o,
  output logic [N_SDRAM-1:0] sdram_clk_o,
  output logic               ref_clk_o,
  output logic               usb_clk_o
);
  logic run_cpu, run_pci, run_free;

  assign run_cpu  = run_req(mode_i, cpu_stop_ni, pwr_dn_ni);
  assign run_pci  = run_req(mode_i, pci_stop_ni, pwr_dn_ni);
  assign run_free = run_req(mode_i, 1'b1,        pwr_dn_ni);

  ckg_gate_lane #(.N(N_CPU), .STAGES(SYNC_STAGES)) u_cpu (
    .clk_i(cpu_clk_i), .rst_ni(rst_ni), .run_i(run_cpu), .en_i(cpu_en_i), .clk_o(cpu_clk_o));

  ckg_gate_lane #(.N(N_PCI), .STAGES(SYNC_STAGES)) u_pci (
    .clk_i(pci_clk_i), .rst_ni(rst_ni), .run_i(run_pci), .en_i(pci_en_i), .clk_o(pci_clk_o));

  // Free-running PCI shares the PCI source but is exempt from PCI stop.
  ckg_gate_lane #(.N(1), .STAGES(SYNC_STAGES)) u_pci_free (
    .clk_i(pci_clk_i), .rst_ni(rst_ni), .run_i(run_free), .en_i(pci_free_en_i),
    .clk_o(pci_free_clk_o));

  ckg_gate_lane #(.N(N_AGP), .STAGES(SYNC_STAGES)) u_agp (
    .clk_i(agp_clk_i), .rst_ni(rst_ni), .run_i(run_free), .en_i(agp_en_i), .clk_o(agp_clk_o));

  ckg_gate_lane #(.N(N_SDRAM), .STAGES(SYNC_STAGES)) u_sdram (
    .clk_i(sdram_clk_i), .rst_ni(rst_ni), .run_i(run_free), .en_i(sdram_en_i),
    .clk_o(sdram_clk_o));

  ckg_gate_lane #(.N(1), .STAGES(SYNC_STAGES)) u_ref (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .run_i(run_free), .en_i(ref_en_i), .clk_o(ref_clk_o));

  ckg_gate_lane #(.N(1), .STAGES(SYNC_STAGES)) u_usb (
    .clk_i(usb_clk_i), .rst_ni(rst_ni), .run_i(run_free), .en_i(usb_en_i), .clk_o(usb_clk_o));
endmodule

// File: rtl/ckg_stop_chk.sv
module ckg_stop_chk #(
  parameter int N_CPU = 4,
  parameter int N_PCI = 4,
  parameter int N_AGP = 2
) (
  input logic             cpu_clk_i,
  input logic             pci_clk_i,
  input logic             agp_clk_i,
  input logic             rst_ni,
  input logic             mode_i,
  input logic             cpu_stop_ni,
  input logic             pci_stop_ni,
  input logic             pwr_dn_ni,
  input logic [N_CPU-1:0] cpu_en_i,
  input logic             pci_free_en_i,
  input logic [N_AGP-1:0] agp_en_i,
  input logic [N_CPU-1:0] cpu_clk_o,
  input logic [N_PCI-1:0] pci_clk_o,
  input logic             pci_free_clk_o,
  input logic [N_AGP-1:0] agp_clk_o
);
  // Falling edges seen since reset, saturating at 4.
  logic [2:0] cpu_cnt, pci_cnt, agp_cnt;

  always_ff @(negedge cpu_clk_i or negedge rst_ni)
    if (!rst_ni) cpu_cnt <= '0; else if (cpu_cnt != 3'd4) cpu_cnt <= cpu_cnt + 3'd1;
  always_ff @(negedge pci_clk_i or negedge rst_ni)
    if (!rst_ni) pci_cnt <= '0; else if (pci_cnt != 3'd4) pci_cnt <= pci_cnt + 3'd1;
  always_ff @(negedge agp_clk_i or negedge rst_ni)
    if (!rst_ni) agp_cnt <= '0; else if (agp_cnt != 3'd4) agp_cnt <= agp_cnt + 3'd1;

  logic cpu_hold, mode_run, pci_hold, pwr_hold, agp_on;
  assign cpu_hold = !mode_i && !cpu_stop_ni;
  assign mode_run = mode_i && (&cpu_en_i);
  assign pci_hold = !mode_i && pwr_dn_ni && pci_free_en_i && !pci_stop_ni;
  assign pwr_hold = !mode_i && !pwr_dn_ni;
  assign agp_on   = pwr_dn_ni && (&agp_en_i);

  p_mode_run_r2: assert property (@(negedge cpu_clk_i) disable iff (!rst_ni)
    (cpu_cnt == 3'd4 && mode_run && $past(mode_run, 1) && $past(mode_run, 2) && $past(mode_run, 3))
    |-> cpu_clk_o == '1);

  p_cpu_stop_r3: assert property (@(negedge cpu_clk_i) disable iff (!rst_ni)
    (cpu_cnt == 3'd4 && cpu_hold && $past(cpu_hold, 1) && $past(cpu_hold, 2) && $past(cpu_hold, 3))
    |-> cpu_clk_o == '0);

  p_pci_free_r5: assert property (@(negedge pci_clk_i) disable iff (!rst_ni)
    (pci_cnt == 3'd4 && pci_hold && $past(pci_hold, 1) && $past(pci_hold, 2) && $past(pci_hold, 3))
    |-> (pci_free_clk_o && pci_clk_o == '0));

  p_agp_free_r6: assert property (@(negedge agp_clk_i) disable iff (!rst_ni)
    (agp_cnt == 3'd4 && agp_on && $past(agp_on, 1) && $past(agp_on, 2) && $past(agp_on, 3))
    |-> agp_clk_o == '1);

  p_pwr_dn_r7: assert property (@(negedge agp_clk_i) disable iff (!rst_ni)
    (agp_cnt == 3'd4 && pwr_hold && $past(pwr_hold, 1) && $past(pwr_hold, 2) && $past(pwr_hold, 3))
    |-> agp_clk_o == '0);

  p_cpu_low_r9: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni) cpu_clk_o == '0);
  p_pci_low_r9: assert property (@(posedge pci_clk_i) disable iff (!rst_ni)
    (pci_clk_o == '0 && !pci_free_clk_o));
  p_agp_low_r9: assert property (@(posedge agp_clk_i) disable iff (!rst_ni) agp_clk_o == '0);
endmodule

bind clk_stop_gate ckg_stop_chk #(.N_CPU(N_CPU), .N_PCI(N_PCI), .N_AGP(N_AGP)) u_chk (
  .cpu_clk_i     (cpu_clk_i),
  .pci_clk_i     (pci_clk_i),
  .agp_clk_i     (agp_clk_i),
  .rst_ni        (rst_ni),
  .mode_i        (mode_i),
  .cpu_stop_ni   (cpu_stop_ni),
  .pci_stop_ni   (pci_stop_ni),
  .pwr_dn_ni     (pwr_dn_ni),
  .cpu_en_i      (cpu_en_i),
  .pci_free_en_i (pci_free_en_i),
  .agp_en_i      (agp_en_i),
  .cpu_clk_o     (cpu_clk_o),
  .pci_clk_o     (pci_clk_o),
  .pci_free_clk_o(pci_free_clk_o),
  .agp_clk_o     (agp_clk_o)
);

// File: tb/sim_clk_stop_gate.sv
`timescale 1ns/1ps
module sim_clk_stop_gate;
  logic cpu_clk = 0, pci_clk = 0, agp_clk = 0, sdram_clk = 0, ref_clk = 0, usb_clk = 0;
  logic rst_n = 0;
  logic mode = 0, cpu_s_n = 1, pci_s_n = 1, pwr_n = 1;
  logic [3:0]  cpu_en = '1;
  logic [3:0]  pci_en = '1;
  logic        pcif_en = 1;
  logic [1:0]  agp_en = '1;
  logic [11:0] sdram_en = '1;
  logic        ref_en = 1, usb_en = 1;

  logic [3:0]  cpu_o, pci_o;
  logic        pcif_o, ref_o, usb_o;
  logic [1:0]  agp_o;
  logic [11:0] sdram_o;
  logic [24:0] obs;

  always #10   cpu_clk   = ~cpu_clk;   // 50 MHz
  always #20   pci_clk   = ~pci_clk;
  always #15   agp_clk   = ~agp_clk;
  always #10.5 sdram_clk = ~sdram_clk;
  always #35   ref_clk   = ~ref_clk;
  always #10.4 usb_clk   = ~usb_clk;

  clk_stop_gate u0 (
    .cpu_clk_i(cpu_clk), .pci_clk_i(pci_clk), .agp_clk_i(agp_clk), .sdram_clk_i(sdram_clk),
    .ref_clk_i(ref_clk), .usb_clk_i(usb_clk), .rst_ni(rst_n), .mode_i(mode),
    .cpu_stop_ni(cpu_s_n), .pci_stop_ni(pci_s_n), .pwr_dn_ni(pwr_n),
    .cpu_en_i(cpu_en), .pci_en_i(pci_en), .pci_free_en_i(pcif_en), .agp_en_i(agp_en),
    .sdram_en_i(sdram_en), .ref_en_i(ref_en), .usb_en_i(usb_en),
    .cpu_clk_o(cpu_o), .pci_clk_o(pci_o), .pci_free_clk_o(pcif_o), .agp_clk_o(agp_o),
    .sdram_clk_o(sdram_o), .ref_clk_o(ref_o), .usb_clk_o(usb_o));

  // Bench-side packing: cpu[3:0], pci[7:4], pci_free[8], agp[10:9], sdram[22:11], ref[23], usb[24].
  assign obs = {usb_o, ref_o, sdram_o, agp_o, pcif_o, pci_o, cpu_o};

  int n_run = 0, n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Which outputs should toggle, computed from the requirements.
  function automatic logic [24:0] exp_mask();
    logic all_run, cpu_run, pci_run;
    all_run = mode | pwr_n;
    cpu_run = mode | (cpu_s_n & pwr_n);
    pci_run = mode | (pci_s_n & pwr_n);
    return {usb_en & all_run, ref_en & all_run, sdram_en & {12{all_run}},
            agp_en & {2{all_run}}, pcif_en & all_run, pci_en & {4{pci_run}},
            cpu_en & {4{cpu_run}}};
  endfunction

  typedef struct {
    string       req;
    logic [24:0] mask;
  } item_t;
  item_t sb_q[$];

  // Driver: let the controls settle, queue the expectation, wait for the monitor.
  task automatic expect_state(input string req);
    item_t it;
    #400;
    it.req  = req;
    it.mask = exp_mask();
    sb_q.push_back(it);
    while (sb_q.size() != 0) #1;
  endtask

  // Monitor: an output counts as active if it was seen high anywhere in the window.
  initial begin
    logic [24:0] act;
    forever begin
      while (sb_q.size() == 0) #1;
      act = '0;
      repeat (400) begin
        #1;
        act = act | obs;
      end
      chk(sb_q[0].req, {7'd0, act}, {7'd0, sb_q[0].mask});
      void'(sb_q.pop_front());
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    #100 rst_n = 1;
    expect_state("R1 reset state all running");

    cpu_s_n = 0;
    expect_state("R3 R6 cpu stop");
    cpu_s_n = 1; pci_s_n = 0;
    expect_state("R5 R6 pci stop, free pci runs");
    cpu_s_n = 0;
    expect_state("R6 both stops, agp sdram ref usb run");
    cpu_s_n = 1; pci_s_n = 1; pwr_n = 0;
    expect_state("R7 power-down");
    cpu_s_n = 0; pci_s_n = 0;
    expect_state("R7 power-down with stops");
    mode = 1;
    expect_state("R2 mode high ignores controls");

    cpu_en = 4'b0101; pci_en = 4'b1010; pcif_en = 0; agp_en = 2'b01;
    sdram_en = 12'hA5C; ref_en = 0; usb_en = 1;
    expect_state("R2 R8 mode high with enable pattern");
    mode = 0; pwr_n = 1; pci_s_n = 1;
    expect_state("R8 R3 enable pattern with cpu stop");
    cpu_s_n = 1;
    expect_state("R8 enable pattern");
    cpu_en = 4'b1010; pci_en = 4'b0110; pcif_en = 1; agp_en = 2'b10;
    sdram_en = 12'h3C1; ref_en = 1; usb_en = 0; pci_s_n = 0;
    expect_state("R8 R5 second pattern with pci stop");

    cpu_en = '1; pci_en = '1; pcif_en = 1; agp_en = '1; sdram_en = '1;
    ref_en = 1; usb_en = 1; pci_s_n = 1;
    expect_state("R1 all restored");

    // R4: CPU domain, stop then restart.
    @(posedge cpu_clk); #5 cpu_s_n = 0;
    @(posedge cpu_clk); #5 chk("R4 cpu stop E1", {28'd0, cpu_o}, 32'hF);
    @(posedge cpu_clk); #5 chk("R4 cpu stop E2", {28'd0, cpu_o}, 32'hF);
    @(posedge cpu_clk); #5 chk("R4 cpu stop E3", {28'd0, cpu_o}, 32'h0);
    #100;
    @(posedge cpu_clk); #5 cpu_s_n = 1;
    @(posedge cpu_clk); #5 chk("R4 cpu start E1", {28'd0, cpu_o}, 32'h0);
    @(posedge cpu_clk); #5 chk("R4 cpu start E2", {28'd0, cpu_o}, 32'h0);
    @(posedge cpu_clk); #5 chk("R4 cpu start E3", {28'd0, cpu_o}, 32'hF);

    // R4: PCI domain, stop then restart; free-running output stays high in its high phases.
    @(posedge pci_clk); #10 pci_s_n = 0;
    @(posedge pci_clk); #10 chk("R4 pci stop E2-1", {27'd0, pcif_o, pci_o}, 32'h1F);
    @(posedge pci_clk); #10 chk("R4 pci stop E2", {27'd0, pcif_o, pci_o}, 32'h1F);
    @(posedge pci_clk); #10 chk("R4 R5 pci stop E3", {27'd0, pcif_o, pci_o}, 32'h10);
    #200;
    @(posedge pci_clk); #10 pci_s_n = 1;
    @(posedge pci_clk); #10 chk("R4 pci start E1", {27'd0, pcif_o, pci_o}, 32'h10);
    @(posedge pci_clk); #10 chk("R4 pci start E2", {27'd0, pcif_o, pci_o}, 32'h10);
    @(posedge pci_clk); #10 chk("R4 pci start E3", {27'd0, pcif_o, pci_o}, 32'h1F);

    // R9: low phase of each source shows no output high.
    @(negedge cpu_clk); #5 chk("R9 cpu low phase", {28'd0, cpu_o}, 32'h0);
    @(negedge agp_clk); #5 chk("R9 agp low phase", {30'd0, agp_o}, 32'h0);

    summary();
    $finish;
  end
endmodule